// File: doc/BRIEF.md
# Byte-Wide Configuration Load and Readback Master

This block drives the byte-wide slave configuration port of a programmable logic device from inside a larger chip. One engine does both jobs. A load command resets the target with a program request and waits until the target reports it is ready. It then writes a stream of bytes, one configuration clock pulse per byte, and keeps pulsing the clock until the target reports that configuration is complete. A readback command selects the target without write enable. It pulses the clock once per byte and hands each captured byte to a valid/ready output stream.

Commands come in on a simple valid/ready interface that carries a mode bit and a byte count. The result leaves as a one-cycle status pulse with an ok flag. Every wait phase is guarded by the same timeout counter: the ready wait after programming, the stall wait after a byte, and the completion wait. When a timeout ends a load, the status reports failure and an abort pulse goes to the target. Stall checking after each byte can be compiled in or out.

Top module: `cfgm_master`

## Requirements
- R1: After reset, cmd_ready is 1. dev_sel, dev_wen, dev_prog_req, dev_doe, dev_abort, rd_valid and st_valid are 0, and dev_sclk is 1. The configuration clock idles high.
- R2: A load command (cmd_rdback=0) raises dev_prog_req for exactly PROG_CYC cycles, with dev_sel and dev_wen low. The block then waits until dev_ready_in=1 and dev_stall=0 before it asserts any other pin.
- R3: If dev_ready_in does not rise within TMO_CYC cycles after the program request ends, the load ends with st_ok=0 and a dev_abort pulse. dev_sel is never asserted and no byte is taken from the write stream.
- R4: During a load, dev_wen rises at least one cycle before dev_sel, and dev_sclk is already high in the cycle before dev_sel rises.
- R5: Each accepted write byte is put on dev_dout. dev_sclk then goes low for one cycle and high again. This gives exactly one rising edge per byte while dev_sel=1 and dev_wen=1, and bytes leave in stream order.
- R6: With stall checking on, if dev_stall=1 after a byte's rising edge, the block issues one extra clock pulse every two cycles. It takes no new byte and keeps dev_dout unchanged until dev_stall falls. A stall longer than TMO_CYC cycles ends the load with st_ok=0 and dev_abort.
- R7: At the end of the write phase, dev_sel falls first and dev_wen falls one cycle later.
- R8: After the write phase, dev_sclk keeps pulsing until dev_cfg_ok=1, and then st_ok=1. If dev_cfg_ok stays low for TMO_CYC cycles, the load ends with st_ok=0 and a dev_abort pulse. st_valid is a single-cycle pulse.
- R9: A readback command (cmd_rdback=1) raises dev_sel with dev_sclk high and dev_wen low. For each byte it drives dev_sclk low for one cycle, then high, and captures dev_din after the rising edge. The bytes go out on rd_data in the order they were read.
- R10: While rd_valid=1 and rd_ready=0, dev_sclk stays high and rd_data stays unchanged, so the target sees no extra clock edge.
- R11: After the last readback byte is taken, dev_sel falls and then exactly one further clock pulse is issued before st_ok=1 is reported.
- R12: dev_doe is 1 only while dev_wen is 1, and it is never 1 while dev_sel=1 and dev_wen=0.
- R13: A byte count of zero is legal. A zero-byte load still programs, waits for readiness and pulses until completion, but never raises wr_ready. A zero-byte readback issues only the single trailing pulse.
- R14: cmd_ready is 1 only when the block is idle. While a command runs, cmd_ready is 0 and the target pins are under the block's control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted (idle) |
| cmd_rdback | input | 1 | 1 = readback, 0 = load |
| cmd_len | input | LEN_W | Number of bytes to move |
| wr_valid | input | 1 | Write stream byte valid |
| wr_ready | output | 1 | Write stream byte taken |
| wr_data | input | DW | Write stream byte |
| rd_valid | output | 1 | Readback byte valid |
| rd_ready | input | 1 | Readback byte consumed |
| rd_data | output | DW | Readback byte |
| st_valid | output | 1 | One-cycle end-of-command pulse |
| st_ok | output | 1 | Result with st_valid: 1 success, 0 failure |
| dev_prog_req | output | 1 | Program request to target, active high |
| dev_sel | output | 1 | Target select, active high |
| dev_wen | output | 1 | Target write enable, active high |
| dev_sclk | output | 1 | Configuration clock, idles high |
| dev_dout | output | DW | Data bus driven toward target |
| dev_doe | output | 1 | Data bus drive enable |
| dev_din | input | DW | Data bus sampled from target |
| dev_ready_in | input | 1 | Target ready for data after programming |
| dev_stall | input | 1 | Target cannot take a clock edge's data |
| dev_cfg_ok | input | 1 | Target reports configuration complete |
| dev_abort | output | 1 | Abort pulse on a failed load |

## Verification
Loads are tried with no stall, with a bounded stall after a chosen byte, with a stall that never clears, with a target that never becomes ready and with a target that never completes. Each fault lands in a different wait phase, so the pulse counts, byte counts and abort flag show which guard fired. Readbacks run once with a consumer that is always ready and once with periodic back-pressure. Any clock edge leaked during a stall would shift the read pattern and raise the target-side edge count. Zero-length commands in both modes check that only the framing pulses appear.

// File: rtl/cfgm_pkg.sv
`timescale 1ns/1ps
// Shared types for the configuration master.
package cfgm_pkg;
    typedef enum logic [4:0] {
        ST_IDLE, ST_PROG, ST_INITW, ST_WEN, ST_SEL, ST_LWAIT, ST_LLO, ST_LHI,
        ST_BLO, ST_BHI, ST_SELOFF, ST_WENOFF, ST_DLO, ST_DHI,
        ST_RSEL, ST_RLO, ST_RHI, ST_RPUT, ST_RSELOFF, ST_RLO2, ST_RHI2, ST_FIN
    } cfgm_state_e;
endpackage

// File: rtl/cfgm_timer.sv
`timescale 1ns/1ps
// Phase timer: counts cycles since the last clear and saturates.
// Assumes PROG_CYC >= 1 and TMO_CYC >= 1 and that W can hold both.
module cfgm_timer #(
    parameter int W        = 8,
    parameter int PROG_CYC = 4,
    parameter int TMO_CYC  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic prog_hit,
    output logic tmo_hit
);
    logic [W-1:0] cnt;

    // Count up from zero after each clear, holding at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (cnt != '1)  cnt <= cnt + 1'b1;
    end

    assign prog_hit = (cnt == W'(PROG_CYC - 1));
    assign tmo_hit  = (cnt >= W'(TMO_CYC - 1));
endmodule

// File: rtl/cfgm_count.sv
`timescale 1ns/1ps
// Remaining-byte counter: loaded from the command, decremented per byte.
module cfgm_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_zero,
    output logic         is_one
);
    logic [W-1:0] rem;

    // Hold the number of bytes still to move.
    always_ff @(posedge clk) begin
        if (!rst_n)              rem <= '0;
        else if (load)           rem <= load_val;
        else if (dec && rem != 0) rem <= rem - 1'b1;
    end

    assign is_zero = (rem == '0);
    assign is_one  = (rem == W'(1));
endmodule

// File: rtl/cfgm_fsm.sv
`timescale 1ns/1ps
// Sequencer for load and readback. Pins are decoded from the state
// register (Moore), so each pin changes only on a state change.
// Assumes the target samples data on the rising configuration clock.
module cfgm_fsm
    import cfgm_pkg::*;
#(
    parameter bit CHECK_BUSY = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic cmd_rdback,
    input  logic wr_valid,
    input  logic rd_ready,
    input  logic dev_ready_in,
    input  logic dev_stall,
    input  logic dev_cfg_ok,
    input  logic cnt_zero,
    input  logic cnt_one,
    input  logic prog_hit,
    input  logic tmo_hit,
    output logic tmr_clr,
    output logic cnt_load,
    output logic cnt_dec,
    output logic cap_wr,
    output logic cap_rd,
    output logic cmd_ready,
    output logic wr_ready,
    output logic rd_valid,
    output logic st_valid,
    output logic st_ok,
    output logic dev_prog_req,
    output logic dev_sel,
    output logic dev_wen,
    output logic dev_sclk,
    output logic dev_doe,
    output logic dev_abort
);
    cfgm_state_e st, nxt;
    logic fail_q, fail_set, fail_clr;
    logic stall_chk;

    generate
        if (CHECK_BUSY) begin : g_stall_on
            assign stall_chk = dev_stall;
        end else begin : g_stall_off
            assign stall_chk = 1'b0;
        end
    endgenerate

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Failure flag for the running command.
    always_ff @(posedge clk) begin
        if (!rst_n)        fail_q <= 1'b0;
        else if (fail_clr) fail_q <= 1'b0;
        else if (fail_set) fail_q <= 1'b1;
    end

    // Next-state and strobe decode.
    always_comb begin
        nxt      = st;
        tmr_clr  = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        cap_wr   = 1'b0;
        cap_rd   = 1'b0;
        fail_set = 1'b0;
        fail_clr = 1'b0;
        case (st)
            ST_IDLE: begin
                tmr_clr = 1'b1;
                if (cmd_valid) begin
                    cnt_load = 1'b1;
                    fail_clr = 1'b1;
                    nxt      = cmd_rdback ? ST_RSEL : ST_PROG;
                end
            end
            ST_PROG: if (prog_hit) begin
                tmr_clr = 1'b1;
                nxt     = ST_INITW;
            end
            ST_INITW: begin
                if (dev_ready_in && !dev_stall) nxt = ST_WEN;
                else if (tmo_hit) begin
                    fail_set = 1'b1;
                    nxt      = ST_FIN;
                end
            end
            ST_WEN:  nxt = ST_SEL;
            ST_SEL:  nxt = cnt_zero ? ST_SELOFF : ST_LWAIT;
            ST_LWAIT: if (wr_valid) begin
                cap_wr  = 1'b1;
                cnt_dec = 1'b1;
                nxt     = ST_LLO;
            end
            ST_LLO:  nxt = ST_LHI;
            ST_LHI: begin
                if (stall_chk) begin
                    tmr_clr = 1'b1;
                    nxt     = ST_BLO;
                end else nxt = cnt_zero ? ST_SELOFF : ST_LWAIT;
            end
            ST_BLO:  nxt = ST_BHI;
            ST_BHI: begin
                if (!stall_chk) nxt = cnt_zero ? ST_SELOFF : ST_LWAIT;
                else if (tmo_hit) begin
                    fail_set = 1'b1;
                    nxt      = ST_SELOFF;
                end else nxt = ST_BLO;
            end
            ST_SELOFF: nxt = ST_WENOFF;
            ST_WENOFF: begin
                if (fail_q || dev_cfg_ok) nxt = ST_FIN;
                else begin
                    tmr_clr = 1'b1;
                    nxt     = ST_DLO;
                end
            end
            ST_DLO:  nxt = ST_DHI;
            ST_DHI: begin
                if (dev_cfg_ok) nxt = ST_FIN;
                else if (tmo_hit) begin
                    fail_set = 1'b1;
                    nxt      = ST_FIN;
                end else nxt = ST_DLO;
            end
            ST_RSEL: nxt = cnt_zero ? ST_RSELOFF : ST_RLO;
            ST_RLO:  nxt = ST_RHI;
            ST_RHI: begin
                cap_rd = 1'b1;
                nxt    = ST_RPUT;
            end
            ST_RPUT: if (rd_ready) begin
                cnt_dec = 1'b1;
                nxt     = cnt_one ? ST_RSELOFF : ST_RLO;
            end
            ST_RSELOFF: nxt = ST_RLO2;
            ST_RLO2:    nxt = ST_RHI2;
            ST_RHI2:    nxt = ST_FIN;
            ST_FIN:     nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // Pin and handshake decode from the current state.
    always_comb begin
        dev_prog_req = (st == ST_PROG);
        dev_wen      = (st inside {ST_WEN, ST_SEL, ST_LWAIT, ST_LLO, ST_LHI,
                                   ST_BLO, ST_BHI, ST_SELOFF});
        dev_sel      = (st inside {ST_SEL, ST_LWAIT, ST_LLO, ST_LHI, ST_BLO,
                                   ST_BHI, ST_RSEL, ST_RLO, ST_RHI, ST_RPUT});
        dev_sclk     = !(st inside {ST_LLO, ST_BLO, ST_DLO, ST_RLO, ST_RLO2});
        dev_doe      = dev_wen;
        cmd_ready    = (st == ST_IDLE);
        wr_ready     = (st == ST_LWAIT);
        rd_valid     = (st == ST_RPUT);
        st_valid     = (st == ST_FIN);
        st_ok        = !fail_q;
        dev_abort    = (st == ST_FIN) && fail_q;
    end
endmodule

// File: rtl/cfgm_master.sv
`timescale 1ns/1ps
// Byte-wide configuration load / readback master (top).
// Joins the sequencer, phase timer, byte counter and the data registers.
// Assumes TMO_CYC > PROG_CYC and that the target drives dev_din only
// while dev_doe is low.
module cfgm_master #(
    parameter int DW         = 8,
    parameter int LEN_W      = 16,
    parameter int PROG_CYC   = 64,
    parameter int TMO_CYC    = 2500000,
    parameter bit CHECK_BUSY = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_rdback,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [DW-1:0]    wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [DW-1:0]    rd_data,
    output logic             st_valid,
    output logic             st_ok,
    output logic             dev_prog_req,
    output logic             dev_sel,
    output logic             dev_wen,
    output logic             dev_sclk,
    output logic [DW-1:0]    dev_dout,
    output logic             dev_doe,
    input  logic [DW-1:0]    dev_din,
    input  logic             dev_ready_in,
    input  logic             dev_stall,
    input  logic             dev_cfg_ok,
    output logic             dev_abort
);
    localparam int TMR_W = $clog2(TMO_CYC + PROG_CYC + 2);

    logic tmr_clr, prog_hit, tmo_hit;
    logic cnt_load, cnt_dec, cnt_zero, cnt_one;
    logic cap_wr, cap_rd;
    logic [DW-1:0] dq_q, rd_q;

    cfgm_timer #(.W(TMR_W), .PROG_CYC(PROG_CYC), .TMO_CYC(TMO_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr),
        .prog_hit(prog_hit), .tmo_hit(tmo_hit)
    );

    cfgm_count #(.W(LEN_W)) u_count (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cmd_len),
        .dec(cnt_dec), .is_zero(cnt_zero), .is_one(cnt_one)
    );

    cfgm_fsm #(.CHECK_BUSY(CHECK_BUSY)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rdback(cmd_rdback),
        .wr_valid(wr_valid), .rd_ready(rd_ready), .dev_ready_in(dev_ready_in),
        .dev_stall(dev_stall), .dev_cfg_ok(dev_cfg_ok), .cnt_zero(cnt_zero),
        .cnt_one(cnt_one), .prog_hit(prog_hit), .tmo_hit(tmo_hit),
        .tmr_clr(tmr_clr), .cnt_load(cnt_load), .cnt_dec(cnt_dec),
        .cap_wr(cap_wr), .cap_rd(cap_rd), .cmd_ready(cmd_ready),
        .wr_ready(wr_ready), .rd_valid(rd_valid), .st_valid(st_valid),
        .st_ok(st_ok), .dev_prog_req(dev_prog_req), .dev_sel(dev_sel),
        .dev_wen(dev_wen), .dev_sclk(dev_sclk), .dev_doe(dev_doe),
        .dev_abort(dev_abort)
    );

    // Outgoing byte: latched when the write stream hands one over.
    always_ff @(posedge clk) begin
        if (!rst_n)      dq_q <= '0;
        else if (cap_wr) dq_q <= wr_data;
    end

    // Readback byte: sampled from the target after the rising clock.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_q <= '0;
        else if (cap_rd) rd_q <= dev_din;
    end

    assign dev_dout = dq_q;
    assign rd_data  = rd_q;
endmodule

// File: rtl/cfgm_master_chk.sv
`timescale 1ns/1ps
// Protocol checker for cfgm_master, attached by bind.
module cfgm_master_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_ready,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic [DW-1:0] rd_data,
    input logic          st_valid,
    input logic          st_ok,
    input logic          dev_prog_req,
    input logic          dev_sel,
    input logic          dev_wen,
    input logic          dev_sclk,
    input logic [DW-1:0] dev_dout,
    input logic          dev_doe,
    input logic          dev_abort
);
    p_prog_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dev_prog_req |-> !dev_sel && !dev_wen);

    p_wen_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_sel) && dev_wen |-> $past(dev_wen));

    p_sclk_high_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_sel) |-> dev_sclk && $past(dev_sclk));

    p_dout_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_sclk) && dev_sel && dev_wen |-> $stable(dev_dout));

    p_sel_drop_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_wen) |-> !$past(dev_sel));

    p_doe_wen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dev_doe |-> dev_wen && !dev_prog_req);

    p_doe_rdback_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dev_sel && !dev_wen |-> !dev_doe);

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && dev_sclk && $stable(dev_sclk));

    p_abort_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dev_abort |-> st_valid && !st_ok);

    p_status_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> !st_valid);

    p_idle_quiet_r14: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !dev_sel && !dev_wen && !dev_prog_req && !st_valid);
endmodule

bind cfgm_master cfgm_master_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .st_valid(st_valid), .st_ok(st_ok),
    .dev_prog_req(dev_prog_req), .dev_sel(dev_sel), .dev_wen(dev_wen),
    .dev_sclk(dev_sclk), .dev_dout(dev_dout), .dev_doe(dev_doe),
    .dev_abort(dev_abort)
);

// File: tb/cfgm_master_tb.sv
`timescale 1ns/1ps
module cfgm_master_tb;
    localparam int DW = 8, LEN_W = 8, PROG_CYC = 3, TMO_CYC = 40;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_ready, cmd_rdback = 1'b0;
    logic [LEN_W-1:0] cmd_len = '0;
    logic wr_valid = 1'b0, wr_ready;
    logic [DW-1:0] wr_data = '0;
    logic rd_valid, rd_ready = 1'b0;
    logic [DW-1:0] rd_data;
    logic st_valid, st_ok;
    logic dev_prog_req, dev_sel, dev_wen, dev_sclk, dev_doe, dev_abort;
    logic [DW-1:0] dev_dout;
    logic [DW-1:0] dev_din = '0;
    logic dev_ready_in = 1'b0, dev_stall = 1'b0, dev_cfg_ok = 1'b0;

    always #2 clk = ~clk;

    cfgm_master #(.DW(DW), .LEN_W(LEN_W), .PROG_CYC(PROG_CYC),
                  .TMO_CYC(TMO_CYC), .CHECK_BUSY(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_rdback(cmd_rdback), .cmd_len(cmd_len), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .rd_data(rd_data), .st_valid(st_valid), .st_ok(st_ok),
        .dev_prog_req(dev_prog_req), .dev_sel(dev_sel), .dev_wen(dev_wen),
        .dev_sclk(dev_sclk), .dev_dout(dev_dout), .dev_doe(dev_doe),
        .dev_din(dev_din), .dev_ready_in(dev_ready_in), .dev_stall(dev_stall),
        .dev_cfg_ok(dev_cfg_ok), .dev_abort(dev_abort)
    );

    int total = 0, bad = 0;
    logic [DW-1:0] exp_wr[$];
    logic [DW-1:0] exp_rd[$];

    // target model configuration and observations
    int init_dly = 0, init_cnt = 0, busy_at = 0, busy_len = 0, busy_left = 0;
    int done_after = 0, wr_seen = 0, stall_pulses = 0, post_pulses = 0;
    int rb_idx = 0, rd_got = 0, prog_cycles = 0;
    logic [DW-1:0] rb_base = '0;
    bit sel_seen = 0, st_seen = 0, st_ok_seen = 0, abort_seen = 0, wr_ready_seen = 0;
    logic sclk_prev = 1'b1;

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Target model and scoreboard monitor, evaluated away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (dev_prog_req) begin
                prog_cycles++;
                init_cnt = 0;
                dev_ready_in <= 1'b0;
                dev_cfg_ok   <= 1'b0;
            end else if (init_dly >= 0 && !dev_ready_in) begin
                if (init_cnt >= init_dly) dev_ready_in <= 1'b1;
                else init_cnt++;
            end
            if (dev_sel) sel_seen = 1;
            if (wr_ready) wr_ready_seen = 1;
            if (dev_sclk && !sclk_prev) begin
                if (dev_sel && dev_wen) begin
                    if (!dev_stall) begin
                        wr_seen++;
                        if (exp_wr.size() == 0) chk(0, "R5 extra byte", int'(dev_dout), -1);
                        else begin
                            logic [DW-1:0] e;
                            e = exp_wr.pop_front();
                            chk(dev_dout == e, "R5 byte order", int'(dev_dout), int'(e));
                        end
                        if (wr_seen == busy_at && busy_len > 0) begin
                            dev_stall <= 1'b1;
                            busy_left = busy_len;
                        end
                    end else begin
                        stall_pulses++;
                        busy_left--;
                        if (busy_left == 0) dev_stall <= 1'b0;
                    end
                end else if (dev_sel && !dev_wen) begin
                    dev_din <= rb_base + DW'(rb_idx);
                    rb_idx++;
                end else if (!dev_sel && !dev_wen) begin
                    post_pulses++;
                    if (done_after > 0 && post_pulses >= done_after) dev_cfg_ok <= 1'b1;
                end
            end
            sclk_prev = dev_sclk;
            if (rd_valid && rd_ready) begin
                rd_got++;
                if (exp_rd.size() == 0) chk(0, "R9 extra read", int'(rd_data), -1);
                else begin
                    logic [DW-1:0] e;
                    e = exp_rd.pop_front();
                    chk(rd_data == e, "R9 read order", int'(rd_data), int'(e));
                end
            end
            if (st_valid) begin
                st_seen = 1;
                st_ok_seen = st_ok;
            end
            if (dev_abort) abort_seen = 1;
        end
    end

    task automatic clear_model();
        init_cnt = 0; wr_seen = 0; stall_pulses = 0; post_pulses = 0;
        rb_idx = 0; rd_got = 0; prog_cycles = 0; busy_left = 0;
        sel_seen = 0; st_seen = 0; st_ok_seen = 0; abort_seen = 0; wr_ready_seen = 0;
        dev_stall <= 1'b0;
        exp_wr.delete();
        exp_rd.delete();
    endtask

    task automatic issue(input bit rdback, input int n);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_rdback = rdback; cmd_len = LEN_W'(n);
        while (!cmd_ready) begin @(posedge clk); #1; end
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_status();
        while (!st_seen) begin @(posedge clk); #1; end
        repeat (3) @(posedge clk);
        #1;
    endtask

    // Load driver: pushes expected bytes into the scoreboard, then feeds them.
    task automatic run_load(input string tag, input int n, input int bat, input int blen,
                            input int idly, input int dafter, input bit exp_ok,
                            input int exp_bytes, input int exp_stall, input int exp_post);
        clear_model();
        busy_at = bat; busy_len = blen; init_dly = idly; done_after = dafter;
        for (int i = 0; i < exp_bytes; i++) exp_wr.push_back(DW'(n * 7 + i * 13 + 1));
        issue(1'b0, n);
        chk(cmd_ready == 1'b0, {tag, " R14 busy"}, int'(cmd_ready), 0);
        for (int i = 0; i < n; i++) begin
            wr_valid = 1'b1;
            wr_data  = DW'(n * 7 + i * 13 + 1);
            while (!wr_ready && !st_seen) begin @(posedge clk); #1; end
            if (st_seen) break;
            @(posedge clk); #1;
            wr_valid = 1'b0;
            if (i % 2 == 1) begin @(posedge clk); #1; end
        end
        wr_valid = 1'b0;
        wait_status();
        chk(st_ok_seen == exp_ok, {tag, " R8 status"}, int'(st_ok_seen), int'(exp_ok));
        chk(abort_seen == !exp_ok, {tag, " R8 abort"}, int'(abort_seen), int'(!exp_ok));
        chk(prog_cycles == PROG_CYC, {tag, " R2 prog width"}, prog_cycles, PROG_CYC);
        chk(wr_seen == exp_bytes, {tag, " R5 byte count"}, wr_seen, exp_bytes);
        if (exp_stall >= 0)
            chk(stall_pulses == exp_stall, {tag, " R6 stall pulses"}, stall_pulses, exp_stall);
        if (exp_post >= 0)
            chk(post_pulses == exp_post, {tag, " R8 done pulses"}, post_pulses, exp_post);
    endtask

    // Readback driver: pushes the expected read pattern, then consumes it.
    task automatic run_dump(input string tag, input int n, input logic [DW-1:0] base,
                            input bit backpressure);
        int cyc = 0;
        clear_model();
        rb_base = base;
        for (int i = 0; i < n; i++) exp_rd.push_back(base + DW'(i));
        issue(1'b1, n);
        while (!st_seen) begin
            rd_ready = backpressure ? (cyc % 3 == 2) : 1'b1;
            cyc++;
            @(posedge clk); #1;
        end
        rd_ready = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(st_ok_seen == 1'b1, {tag, " R11 status"}, int'(st_ok_seen), 1);
        chk(rd_got == n, {tag, " R9 read count"}, rd_got, n);
        chk(exp_rd.size() == 0, {tag, " R9 queue drained"}, exp_rd.size(), 0);
        chk(rb_idx == n, {tag, " R10 target edges"}, rb_idx, n);
        chk(post_pulses == 1, {tag, " R11 trailing pulse"}, post_pulses, 1);
        chk(abort_seen == 0, {tag, " R9 no abort"}, int'(abort_seen), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_ready == 1'b1, "R1 cmd_ready", int'(cmd_ready), 1);
        chk(!dev_sel && !dev_wen && !dev_prog_req, "R1 pins low",
            int'({dev_sel, dev_wen, dev_prog_req}), 0);
        chk(!dev_doe && !dev_abort, "R1 doe/abort low", int'({dev_doe, dev_abort}), 0);
        chk(dev_sclk == 1'b1, "R1 sclk idle high", int'(dev_sclk), 1);
        chk(!rd_valid && !st_valid, "R1 no stream/status", int'({rd_valid, st_valid}), 0);

        // R2 R4 R5 R7 R8: plain load
        run_load("plain", 5, 0, 0, 4, 3, 1'b1, 5, 0, 3);
        chk(exp_wr.size() == 0, "plain R5 queue drained", exp_wr.size(), 0);
        // R6: bounded stall after the second byte
        run_load("stall", 6, 2, 4, 2, 2, 1'b1, 6, 4, 2);
        chk(exp_wr.size() == 0, "stall R6 queue drained", exp_wr.size(), 0);
        // R3: target never ready
        run_load("noinit", 4, 0, 0, -1, 2, 1'b0, 0, 0, 0);
        chk(sel_seen == 0, "noinit R3 never selected", int'(sel_seen), 0);
        chk(wr_ready_seen == 0, "noinit R3 no byte taken", int'(wr_ready_seen), 0);
        // R6: stall never clears
        run_load("stallto", 5, 2, 1000, 1, 2, 1'b0, 2, -1, 0);
        // R8: completion never reported
        run_load("nodone", 3, 0, 0, 1, 0, 1'b0, 3, 0, -1);
        chk(post_pulses > 2, "nodone R8 pulsing continued", post_pulses, 3);
        // R9 R11: readback, consumer always ready
        run_dump("rb", 7, 8'h40, 1'b0);
        // R10: readback with back-pressure
        run_dump("rbbp", 6, 8'hA0, 1'b1);
        // R13: zero-length commands
        run_load("zload", 0, 0, 0, 1, 2, 1'b1, 0, 0, 2);
        chk(wr_ready_seen == 0, "zload R13 no wr_ready", int'(wr_ready_seen), 0);
        run_dump("zdump", 0, 8'h11, 1'b0);
        chk(cmd_ready == 1'b1, "R14 idle after commands", int'(cmd_ready), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule